// File: doc/BRIEF.md
# Next Instruction Address Sequencer

This block owns the 32-bit program counter of a simple in-order core and chooses, on every clock cycle, where the following instruction is fetched from. A decoder presents a three-bit flow code for the instruction now at the PC. It also supplies the result of the register equality comparison, the 16-bit branch displacement, the 26-bit word-granular jump field and a 32-bit register operand. On the next rising edge the sequencer loads the PC with one of four values: the sequential address, a PC-relative branch target, a target within the current 256 MB region, or the register operand.

For calls, the block also presents the return address and a one-cycle write strobe addressed to the link register (register 31), for the register file to capture. For an indirect jump whose operand is not word aligned, it raises a flag and still loads the operand with its two low bits forced to zero. Instruction memory, decoding, the register file, delay slots and exceptions are outside this block.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0x00000000 at that edge, whatever the flow code is, and `link_we` stays low while `rst` is high.
- R2: Flow code 0 (sequential) loads PC+4 at the next edge. The addition wraps modulo 2^32, so 0xFFFFFFFC is followed by 0x00000000.
- R3: Flow code 1 (branch if equal) loads PC + 4 + 4*disp when `cmp_eq` is 1, and PC+4 when `cmp_eq` is 0.
- R4: Flow code 2 (branch if not equal) loads PC + 4 + 4*disp when `cmp_eq` is 0, and PC+4 when `cmp_eq` is 1.
- R5: The branch displacement `br_disp` is a two's-complement value that is sign-extended before it is scaled by 4. For example, 0xFFFF branches to the branch's own address and 0x8000 moves back by 0x20000-4 bytes.
- R6: Flow code 3 (region jump) loads {(PC+4)[31:28], jmp_field, 2'b00}. The region bits come from PC+4, so a jump placed at 0x0FFFFFFC lands in region 0x1.
- R7: Flow code 4 (call) loads the same target as R6. In that same cycle `link_we` is 1, `link_val` equals PC+4 and `link_dst` equals 31.
- R8: `link_we` is 0 in every cycle whose flow code is not 4.
- R9: Flow code 5 (indirect jump) loads `reg_val` with bits [1:0] cleared.
- R10: `misalign` is 1 only in a cycle with flow code 5 and `reg_val[1:0]` nonzero. Otherwise it is 0.
- R11: Flow codes 6 and 7 are unused. They behave as sequential, and `cmp_eq` and `br_disp` have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_sel | input | 3 | Flow code of the current instruction |
| cmp_eq | input | 1 | 1 when the two compared registers are equal |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word address within the current region |
| reg_val | input | 32 | Register operand for indirect jumps |
| pc | output | 32 | Current program counter |
| link_val | output | 32 | Return address (PC+4) |
| link_we | output | 1 | Link register write strobe |
| link_dst | output | 5 | Link register index, always 31 |
| misalign | output | 1 | Indirect jump operand not word aligned |

## Verification
Two things happen together in a call cycle: the return address is handed to the register file, and the PC is redirected to a region target. The bench loads a start PC with an indirect jump, applies a call, and samples `link_we`, `link_val` and `link_dst` before the edge. It then samples the new PC after the edge. Both must hold in that one cycle. The strobe must not appear in any other vector, including jumps and indirect jumps. The misalignment flag and the aligned indirect load fall in the same cycle too. The bench judges the flag before the edge and the cleared low bits after it.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int PCW      = 32;
    localparam int DISP_W   = 16;
    localparam int FIELD_W  = 26;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = PCW - FIELD_W - ALIGN_W;
    localparam int IDX_W    = 5;
    localparam int FLOW_W   = 3;

    typedef logic [PCW-1:0] addr_t;

    typedef enum logic [FLOW_W-1:0] {
        FL_SEQ   = 3'd0,
        FL_BEQ   = 3'd1,
        FL_BNE   = 3'd2,
        FL_JUMP  = 3'd3,
        FL_CALL  = 3'd4,
        FL_IND   = 3'd5,
        FL_RSV6  = 3'd6,
        FL_RSV7  = 3'd7
    } flow_t;

    typedef struct packed {
        addr_t seq;
        addr_t branch;
        addr_t region;
    } targets_t;

    typedef struct packed {
        addr_t next_pc;
        logic  link_hit;
        logic  misalign;
    } decision_t;

    function automatic addr_t scale_disp(input logic [DISP_W-1:0] d);
        addr_t ext;
        ext = {{(PCW-DISP_W){d[DISP_W-1]}}, d};
        return ext << ALIGN_W;
    endfunction

    function automatic addr_t word_clear(input addr_t a);
        return {a[PCW-1:ALIGN_W], {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/pcseq_targets.sv
module pcseq_targets
    import pcseq_pkg::*;
(
    input  addr_t               pc_cur,
    input  logic [DISP_W-1:0]   disp,
    input  logic [FIELD_W-1:0]  field,
    output targets_t            tgt
);
    localparam addr_t STEP = addr_t'(1) << ALIGN_W;

    addr_t seq_a;

    always_comb begin
        seq_a      = pc_cur + STEP;
        tgt.seq    = seq_a;
        tgt.branch = seq_a + scale_disp(disp);
        tgt.region = {seq_a[PCW-1 -: REGION_W], field, {ALIGN_W{1'b0}}};
    end
endmodule

// File: rtl/pcseq_resolve.sv
module pcseq_resolve
    import pcseq_pkg::*;
(
    input  flow_t      flow,
    input  logic       eq,
    input  targets_t   tgt,
    input  addr_t      rval,
    output decision_t  dec
);
    logic taken;

    always_comb begin
        taken        = 1'b0;
        dec.next_pc  = tgt.seq;
        dec.link_hit = 1'b0;
        dec.misalign = 1'b0;
        unique case (flow)
            FL_BEQ: begin
                taken = eq;
                if (taken) dec.next_pc = tgt.branch;
            end
            FL_BNE: begin
                taken = !eq;
                if (taken) dec.next_pc = tgt.branch;
            end
            FL_JUMP: dec.next_pc = tgt.region;
            FL_CALL: begin
                dec.next_pc  = tgt.region;
                dec.link_hit = 1'b1;
            end
            FL_IND: begin
                dec.next_pc  = word_clear(rval);
                dec.misalign = |rval[ALIGN_W-1:0];
            end
            default: dec.next_pc = tgt.seq;
        endcase
    end
endmodule

// File: rtl/pcseq_pcreg.sv
module pcseq_pcreg
    import pcseq_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t d,
    output addr_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RESET_PC;
        else     q <= d;
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter logic [PCW-1:0]   RESET_PC = '0,
    parameter logic [IDX_W-1:0] LINK_REG = 5'd31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [FLOW_W-1:0]    flow_sel,
    input  logic                 cmp_eq,
    input  logic [DISP_W-1:0]    br_disp,
    input  logic [FIELD_W-1:0]   jmp_field,
    input  logic [PCW-1:0]       reg_val,
    output logic [PCW-1:0]       pc,
    output logic [PCW-1:0]       link_val,
    output logic                 link_we,
    output logic [IDX_W-1:0]     link_dst,
    output logic                 misalign
);
    targets_t  tgt;
    decision_t dec;
    addr_t     pc_q;

    pcseq_targets u_tgt (
        .pc_cur (pc_q),
        .disp   (br_disp),
        .field  (jmp_field),
        .tgt    (tgt)
    );

    pcseq_resolve u_res (
        .flow (flow_t'(flow_sel)),
        .eq   (cmp_eq),
        .tgt  (tgt),
        .rval (reg_val),
        .dec  (dec)
    );

    pcseq_pcreg #(.RESET_PC(RESET_PC)) u_pc (
        .clk (clk),
        .rst (rst),
        .d   (dec.next_pc),
        .q   (pc_q)
    );

    assign pc       = pc_q;
    assign link_val = tgt.seq;
    assign link_we  = dec.link_hit && !rst;
    assign link_dst = LINK_REG;
    assign misalign = dec.misalign && !rst;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
    import pcseq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [FLOW_W-1:0] flow_sel,
    input logic              cmp_eq,
    input logic [PCW-1:0]    reg_val,
    input logic [PCW-1:0]    pc,
    input logic [PCW-1:0]    link_val,
    input logic              link_we,
    input logic              misalign
);
    // R1: reset forces the PC to zero on the next edge
    p_reset_pc_r1: assert property (@(posedge clk) rst |=> pc == '0);

    // R2: sequential step
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        flow_sel == 3'd0 |=> pc == $past(pc) + 32'd4);

    // R4: not-equal branch falls through when operands match
    p_bne_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (flow_sel == 3'd2 && cmp_eq) |=> pc == $past(pc) + 32'd4);

    // R7: the strobe carries the return address of the current PC
    p_link_val_r7: assert property (@(posedge clk) disable iff (rst)
        link_we |-> link_val == pc + 32'd4);

    // R7: after a call the PC stays in the region of the return address
    p_call_region_r7: assert property (@(posedge clk) disable iff (rst)
        link_we |=> pc[PCW-1 -: REGION_W] == $past(link_val[PCW-1 -: REGION_W]));

    // R9: indirect jump loads the operand word address
    p_ind_load_r9: assert property (@(posedge clk) disable iff (rst)
        flow_sel == 3'd5 |=> pc == {$past(reg_val[PCW-1:2]), 2'b00});

    // R10: a flagged operand is never loaded with its low bits
    p_mis_clear_r10: assert property (@(posedge clk) disable iff (rst)
        misalign |=> pc[1:0] == 2'b00 && $past(reg_val[1:0]) != 2'b00);

    // R6: the PC is always word aligned out of reset
    p_pc_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);
endmodule

bind pc_sequencer pcseq_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .flow_sel (flow_sel),
    .cmp_eq   (cmp_eq),
    .reg_val  (reg_val),
    .pc       (pc),
    .link_val (link_val),
    .link_we  (link_we),
    .misalign (misalign)
);

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  flow_sel = 3'd0;
    logic        cmp_eq = 1'b0;
    logic [15:0] br_disp = '0;
    logic [25:0] jmp_field = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] pc, link_val;
    logic        link_we, misalign;
    logic [4:0]  link_dst;

    int checks = 0;
    int fails  = 0;

    always #HALF clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst(rst), .flow_sel(flow_sel), .cmp_eq(cmp_eq),
        .br_disp(br_disp), .jmp_field(jmp_field), .reg_val(reg_val),
        .pc(pc), .link_val(link_val), .link_we(link_we),
        .link_dst(link_dst), .misalign(misalign)
    );

    typedef struct packed {
        logic [31:0] start;
        logic [2:0]  flow;
        logic        eq;
        logic [15:0] disp;
        logic [25:0] fld;
        logic [31:0] rv;
        logic [31:0] exp_pc;
        logic        exp_we;
        logic        exp_mis;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 3'd0, 1'b0, 16'd0,    26'd0,       32'd0,        32'h0000_1004, 1'b0, 1'b0, 8'd2},  // R2
        '{32'h0000_1000, 3'd1, 1'b1, 16'd25,   26'd0,       32'd0,        32'h0000_1068, 1'b0, 1'b0, 8'd3},  // R3 taken
        '{32'h0000_1000, 3'd1, 1'b0, 16'd25,   26'd0,       32'd0,        32'h0000_1004, 1'b0, 1'b0, 8'd3},  // R3 not taken
        '{32'h0000_1000, 3'd2, 1'b0, 16'd25,   26'd0,       32'd0,        32'h0000_1068, 1'b0, 1'b0, 8'd4},  // R4 taken
        '{32'h0000_1000, 3'd2, 1'b1, 16'd25,   26'd0,       32'd0,        32'h0000_1004, 1'b0, 1'b0, 8'd4},  // R4 not taken
        '{32'h0000_1000, 3'd1, 1'b1, 16'hFFFF, 26'd0,       32'd0,        32'h0000_1000, 1'b0, 1'b0, 8'd5},  // R5 self
        '{32'h0000_1000, 3'd2, 1'b0, 16'h8000, 26'd0,       32'd0,        32'hFFFE_1004, 1'b0, 1'b0, 8'd5},  // R5 far back
        '{32'h4000_0000, 3'd3, 1'b0, 16'd0,    26'd2500,    32'd0,        32'h4000_2710, 1'b0, 1'b0, 8'd6},  // R6
        '{32'h0FFF_FFFC, 3'd3, 1'b0, 16'd0,    26'd2500,    32'd0,        32'h1000_2710, 1'b0, 1'b0, 8'd6},  // R6 region edge
        '{32'h2000_0010, 3'd4, 1'b1, 16'd25,   26'h3FF_FFFF, 32'd0,       32'h2FFF_FFFC, 1'b1, 1'b0, 8'd7},  // R7 call
        '{32'h0000_1000, 3'd5, 1'b0, 16'd0,    26'd0,       32'h00AB_CDE0, 32'h00AB_CDE0, 1'b0, 1'b0, 8'd9}, // R9
        '{32'h0000_1000, 3'd5, 1'b0, 16'd0,    26'd0,       32'h1234_5677, 32'h1234_5674, 1'b0, 1'b1, 8'd10},// R10
        '{32'h0000_1000, 3'd5, 1'b1, 16'd0,    26'd0,       32'h0000_0002, 32'h0000_0000, 1'b0, 1'b1, 8'd10},// R10
        '{32'h0000_1000, 3'd6, 1'b1, 16'd25,   26'd0,       32'd0,        32'h0000_1004, 1'b0, 1'b0, 8'd11}, // R11
        '{32'h0000_1000, 3'd7, 1'b0, 16'd25,   26'd7,       32'h0000_0003, 32'h0000_1004, 1'b0, 1'b0, 8'd11}, // R11
        '{32'hFFFF_FFFC, 3'd0, 1'b0, 16'd0,    26'd0,       32'd0,        32'h0000_0000, 1'b0, 1'b0, 8'd2}   // R2 wrap
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] f, input logic e, input logic [15:0] d,
                         input logic [25:0] j, input logic [31:0] r);
        flow_sel = f; cmp_eq = e; br_disp = d; jmp_field = j; reg_val = r;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset with a call code pending
        drive(3'd4, 1'b0, 16'd0, 26'h155, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 pc", pc, 32'h0);
        check("R1 link_we", {31'd0, link_we}, 32'd0);

        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            // preload start PC via an aligned indirect jump
            drive(3'd5, 1'b0, 16'd0, 26'd0, v.start);
            @(negedge clk);
            check($sformatf("R9 preload v%0d", i), pc, v.start);
            drive(v.flow, v.eq, v.disp, v.fld, v.rv);
            #5ns;
            check($sformatf("R%0d link_we v%0d", v.req, i), {31'd0, link_we}, {31'd0, v.exp_we}); // R7 R8
            check($sformatf("R%0d misalign v%0d", v.req, i), {31'd0, misalign}, {31'd0, v.exp_mis}); // R10
            if (v.exp_we) begin
                check("R7 link_val", link_val, v.start + 32'd4);
                check("R7 link_dst", {27'd0, link_dst}, 32'd31);
            end
            @(negedge clk);
            check($sformatf("R%0d next pc v%0d", v.req, i), pc, v.exp_pc);
        end

        // R1: synchronous reset mid-run overrides a jump
        drive(3'd3, 1'b0, 16'd0, 26'd2500, 32'd0);
        rst = 1'b1;
        #5ns;
        check("R1 link_we in reset", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        check("R1 pc after reset", pc, 32'h0);
        rst = 1'b0;

        // R8: plain jump from zero raises no strobe, lands at 10000
        #5ns;
        check("R8 jump no strobe", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        check("R6 jump from reset", pc, 32'h0000_2710);

        // R3/R7 back-to-back: call then sequential
        drive(3'd4, 1'b0, 16'd0, 26'd16, 32'd0);
        #5ns;
        check("R7 link_val chain", link_val, 32'h0000_2714);
        @(negedge clk);
        check("R7 call target", pc, 32'h0000_0040);
        drive(3'd0, 1'b0, 16'd0, 26'd0, 32'd0);
        #5ns;
        check("R8 strobe drops", {31'd0, link_we}, 32'd0);
        @(negedge clk);
        check("R2 after call", pc, 32'h0000_0044);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule